// File: doc/BRIEF.md
# Ethernet Destination Address Filter

This block sits behind the receive byte stream of an Ethernet MAC. It decides whether a frame is kept, judging only by the 48-bit destination address. The six address bytes arrive one per valid cycle, and the first of them is flagged as the start of a frame. In the cycle after the sixth byte, the block raises a one-cycle decision strobe together with an accept flag. Any bytes after the address are not looked at.

The address can be accepted in several ways, depending on its kind. A unicast address must equal a single programmed station address. A multicast address is tested against a 256-bit hash table indexed from the CRC-32 of the address, or is taken without any lookup when pass-all-multicast is on. The all-ones broadcast address is taken unless broadcast is switched off. Promiscuous mode takes everything. A simple write port programs the mode bits, the station address and the eight hash words.

Top module: `dest_addr_filter`

## Requirements
- R1: While reset is high and in the cycle after it, `decision_valid` and `accept` are low. Reset clears the mode bits and the station address to zero.
- R2: `decision_valid` is high for exactly one cycle: the cycle after the sixth address byte is taken. Bytes after the sixth, and valid cycles before any frame start, give no further decision. Idle cycles between address bytes are allowed. `accept` is low whenever `decision_valid` is low.
- R3: A byte with `rx_sof` high always begins a new address, which abandons any address that was only partly received.
- R4: A frame whose group bit (bit 0 of the first address byte) is clear is accepted only if all six bytes equal the station address. Station register 1 holds bytes 0..3 in bits 7:0, 15:8, 23:16 and 31:24. Register 2 holds byte 4 in bits 7:0 and byte 5 in bits 15:8.
- R5: With hash enable set, the block accepts a non-broadcast group address when its hash bit is set. The hash bit is found as follows. Run the reflected CRC-32 (polynomial 0xEDB88320, start value all ones, bytes taken LSB first, no final inversion) over the six bytes. Invert the low 8 bits of the result and reverse their bit order to get the index. Index bits 7:5 pick hash word 0..7 and bits 4:0 pick the bit within that word.
- R6: With pass-all-multicast set, every group address is accepted.
- R7: With promiscuous set, every address is accepted, including broadcast when broadcast is disabled.
- R8: The all-ones address is accepted unless the broadcast-disable bit is set.
- R9: A non-broadcast group address is rejected when neither hash enable nor pass-all-multicast is set.
- R10: A register write in the same cycle as the sixth address byte does not affect that frame's decision. It applies from the next frame on.
- R11: The register map is: address 0 holds the mode bits (bit 0 promiscuous, bit 1 pass-all-multicast, bit 2 hash enable, bit 3 broadcast disable); address 1 holds station low; address 2 holds station high; addresses 8..15 hold hash words 0..7. Writes to addresses 3..7 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | A received byte is present |
| rx_sof | input | 1 | The present byte is the first byte of a frame |
| rx_byte | input | 8 | Received byte |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register write address |
| cfg_wdata | input | 32 | Register write data |
| decision_valid | output | 1 | One-cycle strobe: a decision is present |
| accept | output | 1 | The frame is accepted; meaningful with `decision_valid` |

## Verification
Two events can fall in the same cycle: a register write, and the final address byte that triggers the decision. The bench provokes this by overwriting station low in exactly the cycle of the sixth byte of a frame that matches the old station address. It requires that frame to be accepted and the next identical frame to be rejected. The bench also lets a new frame start arrive while an address is only half received, which checks that the restart beats the unfinished capture. Its behavioural model applies register writes after it evaluates the decision in each clock, and compares both outputs on every cycle.

// File: rtl/filt_pkg.sv
package filt_pkg;

  localparam logic [31:0] CRC_POLY_REFL = 32'hEDB88320;

  typedef struct packed {
    logic bcast_off;
    logic hash_on;
    logic all_multi;
    logic promisc;
  } filt_mode_t;

  // One byte of reflected CRC-32, least significant bit first.
  function automatic logic [31:0] crc_step_byte(input logic [31:0] c_in,
                                                input logic [7:0]  d);
    logic [31:0] c;
    c = c_in ^ {24'd0, d};
    for (int i = 0; i < 8; i++) begin
      c = c[0] ? ((c >> 1) ^ CRC_POLY_REFL) : (c >> 1);
    end
    return c;
  endfunction

endpackage

// File: rtl/filt_cfg.sv
module filt_cfg
  import filt_pkg::*;
#(
  parameter int HASH_WORDS = 8,
  parameter int WORD_W     = 32,
  parameter int ADDR_BYTES = 6,
  localparam int AW   = $clog2(2 * HASH_WORDS),
  localparam int WSEL = $clog2(HASH_WORDS),
  localparam int BITW = $clog2(WORD_W),
  localparam int IDXW = WSEL + BITW,
  localparam int STW  = 8 * ADDR_BYTES
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [AW-1:0]     addr,
  input  logic [WORD_W-1:0] wdata,
  input  logic [IDXW-1:0]   hash_idx,
  output filt_mode_t        mode,
  output logic [STW-1:0]    station,
  output logic              hash_hit
);
  localparam int HIW = STW - WORD_W;

  filt_mode_t        mode_q;
  logic [WORD_W-1:0] lo_q;
  logic [HIW-1:0]    hi_q;
  logic [WORD_W-1:0] hash_mem [HASH_WORDS];
  logic [WORD_W-1:0] hash_word;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= '0;
      lo_q   <= '0;
      hi_q   <= '0;
    end else if (we) begin
      if (addr == AW'(0)) mode_q <= filt_mode_t'(wdata[3:0]);
      if (addr == AW'(1)) lo_q   <= wdata;
      if (addr == AW'(2)) hi_q   <= wdata[HIW-1:0];
    end
  end

  // Hash table: plain write port, asynchronous read (LUT RAM friendly).
  always_ff @(posedge clk) begin
    if (we && addr[AW-1]) hash_mem[addr[WSEL-1:0]] <= wdata;
  end

  assign hash_word = hash_mem[hash_idx[IDXW-1:BITW]];
  assign hash_hit  = hash_word[hash_idx[BITW-1:0]];
  assign mode      = mode_q;
  assign station   = {hi_q, lo_q};

  AST_LO_WRITE: assert property (@(posedge clk) disable iff (rst)
    (we && addr == AW'(1)) |=> (lo_q == $past(wdata))); // R11

  AST_MODE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!we) |=> $stable(mode_q)); // R11

endmodule

// File: rtl/filt_capture.sv
module filt_capture
  import filt_pkg::*;
#(
  parameter int ADDR_BYTES = 6,
  localparam int STW = 8 * ADDR_BYTES,
  localparam int CW  = $clog2(ADDR_BYTES + 1)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           rx_valid,
  input  logic           rx_sof,
  input  logic [7:0]     rx_byte,
  output logic           addr_done,
  output logic [STW-1:0] dest_next,
  output logic [31:0]    crc_next
);
  logic [CW-1:0]  cnt_q;
  logic [STW-1:0] dest_q;
  logic [31:0]    crc_q;
  logic           take;

  always_comb begin
    take      = rx_valid && (rx_sof || (cnt_q != '0 && cnt_q < CW'(ADDR_BYTES)));
    addr_done = rx_valid && (rx_sof ? (ADDR_BYTES == 1)
                                    : (cnt_q == CW'(ADDR_BYTES - 1)));
    crc_next  = crc_step_byte(rx_sof ? 32'hFFFF_FFFF : crc_q, rx_byte);
    dest_next = {rx_byte, dest_q[STW-1:8]};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      dest_q <= '0;
      crc_q  <= '1;
    end else if (take) begin
      cnt_q  <= rx_sof ? CW'(1) : cnt_q + CW'(1);
      dest_q <= dest_next;
      crc_q  <= crc_next;
    end
  end

  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CW'(ADDR_BYTES)); // R2

  AST_SOF_RESTART: assert property (@(posedge clk) disable iff (rst)
    (rx_valid && rx_sof) |=> (cnt_q == CW'(1))); // R3

endmodule

// File: rtl/filt_decide.sv
module filt_decide
  import filt_pkg::*;
#(
  parameter int ADDR_BYTES = 6,
  parameter int IDXW       = 8,
  localparam int STW = 8 * ADDR_BYTES
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            addr_done,
  input  logic [STW-1:0]  dest,
  input  logic [31:0]     crc,
  input  filt_mode_t      mode,
  input  logic [STW-1:0]  station,
  input  logic            hash_hit,
  output logic [IDXW-1:0] hash_idx,
  output logic            valid,
  output logic            accept
);
  logic [IDXW-1:0] inv_low;
  logic            is_group, is_bcast, take_it;

  always_comb begin
    inv_low = ~crc[IDXW-1:0];
    for (int i = 0; i < IDXW; i++) hash_idx[i] = inv_low[IDXW-1-i];
    is_group = dest[0];
    is_bcast = &dest;
    if (mode.promisc)  take_it = 1'b1;
    else if (is_bcast) take_it = !mode.bcast_off;
    else if (is_group) take_it = mode.all_multi || (mode.hash_on && hash_hit);
    else               take_it = (dest == station);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid  <= 1'b0;
      accept <= 1'b0;
    end else begin
      valid  <= addr_done;
      accept <= addr_done && take_it;
    end
  end

  AST_PROMISC_WINS: assert property (@(posedge clk) disable iff (rst)
    (addr_done && mode.promisc) |=> accept); // R7

  AST_UNICAST_MISS: assert property (@(posedge clk) disable iff (rst)
    (addr_done && !mode.promisc && !dest[0] && dest != station) |=> !accept); // R4

endmodule

// File: rtl/dest_addr_filter.sv
module dest_addr_filter
  import filt_pkg::*;
#(
  parameter int ADDR_BYTES = 6,
  parameter int HASH_WORDS = 8,
  parameter int WORD_W     = 32
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            rx_valid,
  input  logic                            rx_sof,
  input  logic [7:0]                      rx_byte,
  input  logic                            cfg_we,
  input  logic [$clog2(2*HASH_WORDS)-1:0] cfg_addr,
  input  logic [WORD_W-1:0]               cfg_wdata,
  output logic                            decision_valid,
  output logic                            accept
);
  localparam int STW  = 8 * ADDR_BYTES;
  localparam int IDXW = $clog2(HASH_WORDS) + $clog2(WORD_W);

  logic            addr_done, hash_hit;
  logic [STW-1:0]  dest_next, station;
  logic [31:0]     crc_next;
  logic [IDXW-1:0] hash_idx;
  filt_mode_t      mode;

  filt_capture #(.ADDR_BYTES(ADDR_BYTES)) u_cap (
    .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_sof(rx_sof),
    .rx_byte(rx_byte), .addr_done(addr_done), .dest_next(dest_next),
    .crc_next(crc_next)
  );

  filt_cfg #(.HASH_WORDS(HASH_WORDS), .WORD_W(WORD_W),
             .ADDR_BYTES(ADDR_BYTES)) u_cfg (
    .clk(clk), .rst(rst), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .hash_idx(hash_idx), .mode(mode), .station(station), .hash_hit(hash_hit)
  );

  filt_decide #(.ADDR_BYTES(ADDR_BYTES), .IDXW(IDXW)) u_dec (
    .clk(clk), .rst(rst), .addr_done(addr_done), .dest(dest_next),
    .crc(crc_next), .mode(mode), .station(station), .hash_hit(hash_hit),
    .hash_idx(hash_idx), .valid(decision_valid), .accept(accept)
  );

  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (rst)
    decision_valid |=> !decision_valid); // R2

  AST_QUIET_ACCEPT: assert property (@(posedge clk) disable iff (rst)
    !decision_valid |-> !accept); // R2

endmodule

// File: tb/tb_dest_addr_filter.sv
`timescale 1ns/1ps
module tb_dest_addr_filter;
  logic        clk = 1'b0, rst = 1'b1;
  logic        rx_valid = 1'b0, rx_sof = 1'b0;
  logic [7:0]  rx_byte = '0;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic        decision_valid, accept;

  dest_addr_filter dut (
    .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_sof(rx_sof),
    .rx_byte(rx_byte), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .decision_valid(decision_valid), .accept(accept)
  );

  always #2 clk = ~clk;

  int    vectors = 0, misses = 0, cycles = 0;
  string tag = "R1";
  bit    started = 0;

  // Behavioural reference model
  byte unsigned q[$];
  bit           exp_v = 0, exp_a = 0, m_took;
  bit [31:0]    m_mode = 0, m_lo = 0, m_hi = 0;
  bit [31:0]    m_hash[8];

  function automatic bit [31:0] ref_crc(input bit [47:0] a);
    bit [31:0] c = 32'hFFFF_FFFF;
    for (int k = 0; k < 6; k++) begin
      c ^= {24'd0, a[8*k +: 8]};
      for (int j = 0; j < 8; j++) c = c[0] ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
    end
    return c;
  endfunction

  function automatic bit [7:0] ref_index(input bit [47:0] a);
    bit [7:0] v = ~ref_crc(a)[7:0];
    bit [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = v[7-i];
    return r;
  endfunction

  function automatic bit ref_accept(input bit [47:0] a);
    bit [47:0] st = {m_hi[15:0], m_lo};
    bit [7:0]  ix = ref_index(a);
    if (m_mode[0]) return 1;
    if (a == 48'hFFFF_FFFF_FFFF) return !m_mode[3];
    if (a[0]) return m_mode[1] || (m_mode[2] && m_hash[ix[7:5]][ix[4:0]]);
    return a == st;
  endfunction

  always @(posedge clk) begin
    started = 1;
    cycles++;
    if (rst) begin
      q.delete(); exp_v = 0; exp_a = 0; m_mode = 0; m_lo = 0; m_hi = 0;
    end else begin
      m_took = 0; exp_v = 0; exp_a = 0;
      if (rx_valid) begin
        if (rx_sof) begin q.delete(); q.push_back(rx_byte); m_took = 1; end
        else if (q.size() > 0 && q.size() < 6) begin q.push_back(rx_byte); m_took = 1; end
      end
      if (m_took && q.size() == 6) begin
        bit [47:0] a;
        for (int k = 0; k < 6; k++) a[8*k +: 8] = q[k];
        exp_v = 1;
        exp_a = ref_accept(a);
      end
      // writes land after the decision of this edge (R10)
      if (cfg_we) begin
        if (cfg_addr == 4'd0) m_mode = {28'd0, cfg_wdata[3:0]};
        else if (cfg_addr == 4'd1) m_lo = cfg_wdata;
        else if (cfg_addr == 4'd2) m_hi = {16'd0, cfg_wdata[15:0]};
        else if (cfg_addr >= 4'd8) m_hash[int'(cfg_addr) - 8] = cfg_wdata;
      end
    end
    if (cycles > 50000) begin
      misses++;
      $display("FAIL watchdog: actual cycles %0d expected below 50000", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

  always @(negedge clk) begin
    if (started) begin
      vectors++;
      if (decision_valid !== exp_v || accept !== exp_a) begin
        misses++;
        $display("FAIL %s: valid/accept actual %0b/%0b expected %0b/%0b",
                 tag, decision_valid, accept, exp_v, exp_a);
      end
    end
  end

  task automatic wr(input int a, input bit [31:0] d);
    @(negedge clk); cfg_we = 1; cfg_addr = 4'(a); cfg_wdata = d;
    @(negedge clk); cfg_we = 0;
  endtask

  task automatic send(input bit [7:0] b, input bit sof);
    @(negedge clk); rx_valid = 1; rx_sof = sof; rx_byte = b;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); rx_valid = 0; rx_sof = 0; cfg_we = 0;
    end
  endtask

  task automatic frame(input bit [47:0] a, input bit gaps);
    for (int k = 0; k < 6; k++) begin
      send(a[8*k +: 8], k == 0);
      if (gaps) idle(1);
    end
    send(8'h55, 0); send(8'hAA, 0);
    idle(3);
  endtask

  task automatic frame_cw(input bit [47:0] a, input int ca, input bit [31:0] cd);
    for (int k = 0; k < 5; k++) send(a[8*k +: 8], k == 0);
    @(negedge clk);
    rx_valid = 1; rx_sof = 0; rx_byte = a[47:40];
    cfg_we = 1; cfg_addr = 4'(ca); cfg_wdata = cd;
    idle(3);
  endtask

  localparam bit [47:0] STA  = 48'h5544_3322_1102;
  localparam bit [47:0] MA   = 48'h0100_005E_0001;
  localparam bit [47:0] MB   = 48'hCCBB_AA99_8801;
  localparam bit [47:0] BCST = 48'hFFFF_FFFF_FFFF;

  initial begin
    bit [7:0] ix;
    tag = "R1";
    repeat (3) @(negedge clk);
    rst = 0;
    idle(2);
    for (int w = 0; w < 8; w++) wr(8 + w, 32'd0);
    wr(1, 32'h3322_1102);
    wr(2, 32'h0000_5544);

    tag = "R4"; frame(STA, 0);                       // accept
    frame(48'h5644_3322_1102, 0);                    // reject, last byte
    frame(48'h5544_3322_1104, 0);                    // reject, first byte
    tag = "R2"; frame(STA, 1);                       // gaps between bytes
    send(8'h02, 0); idle(2);                         // stray byte, no frame
    tag = "R3";
    send(8'h10, 1); send(8'h20, 0); send(8'h30, 0);
    frame(STA, 0);                                   // restart mid-address
    tag = "R9"; frame(MA, 0);
    tag = "R5";
    ix = ref_index(MA);
    wr(8 + int'(ix[7:5]), 32'd1 << ix[4:0]);
    wr(0, 32'd4);
    frame(MA, 0);
    frame(MB, 0);
    wr(8 + int'(ix[7:5]), 32'd0);
    frame(MA, 0);
    tag = "R6"; wr(0, 32'd2); frame(MB, 0); frame(MA, 1);
    tag = "R8"; wr(0, 32'd0); frame(BCST, 0);
    wr(0, 32'd8); frame(BCST, 0);
    tag = "R7"; wr(0, 32'd9); frame(BCST, 0);
    frame(48'h0102_0304_0506, 0);
    tag = "R10"; wr(0, 32'd0);
    frame_cw(STA, 1, 32'hDEAD_BEEF);
    frame(STA, 0);
    wr(1, 32'h3322_1102);
    frame(STA, 0);
    tag = "R11";
    wr(4, 32'd1); wr(3, 32'd1); wr(5, 32'hFFFF_FFFF);
    frame(48'h0102_0304_0506, 0);
    frame(STA, 0);
    wr(2, 32'h0000_6677);
    frame(48'h7766_3322_1102, 0);
    idle(4);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule